// File: doc/BRIEF.md
# Dual-Range Modular 2/3 Feedback Divider

This block divides a fast synthesizer clock by a programmable integer for the feedback path of an integer-N frequency synthesizer. It is built from a chain of identical divide-by-2/3 cells. Each cell passes a clock enable forward to the next cell. A modulus-control signal travels the other way, from the last active cell back towards the first. Once in every output period, each cell whose program bit is set stretches one of its own periods by a single input period. Cell `i` therefore adds `2^i` fast cycles, and the total ratio is `2^n` plus the binary value of the program word.

The chain length is chosen by one select pin. Short mode uses eight cells (ratios 256 to 511) and long mode uses ten cells (ratios 1024 to 2047). This lets one structure serve two reference/band plans. Cells above the chosen length are held idle, and the modulus input of the last active cell is forced high, so the shorter chain ends cleanly. The program word and the length select are captured only where one output period ends and the next begins, so a change never produces a truncated or merged period. The output is one fast-clock-wide pulse per divided period, which is the edge a phase detector consumes. This block carries no data stream; every pin is a plain control or clock-rate signal.

Top module: `dm23_divider`

## Requirements
- R1: `div_out` is high for exactly one fast clock cycle per divided period, and is low on the fast cycle that follows every pulse.
- R2: With `long_sel` = 0, consecutive `div_out` pulses are 256 + `prog[7:0]` fast cycles apart.
- R3: With `long_sel` = 1, consecutive `div_out` pulses are 1024 + `prog[9:0]` fast cycles apart.
- R4: The end ratios are reached: an all-zero program word gives 256 (short) or 1024 (long), and an all-one word gives 511 (short) or 2047 (long). No interval is ever longer than 2047 cycles.
- R5: In short mode, `prog[9:8]` has no effect on the interval, and the two upper cells stay idle.
- R6: `prog` and `long_sel` are sampled only at the clock edge on which a divided period ends (the same edge that raises `div_out`). The sampled values govern the period that starts there. A change made at any other time leaves the period in progress at its full old length.
- R7: While `rst_n` is low, `div_out` is low and the configuration pins are sampled on every edge. After release, the first pulse appears on the R-th rising edge with `rst_n` high, where R is the ratio set by the pins held across the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| long_sel | input | 1 | Chain length: 0 selects eight cells, 1 selects ten cells |
| prog | input | 10 | Program word; bit i enables the one-cycle stretch of cell i |
| div_out | output | 1 | One-cycle pulse marking the start of each divided period |

## Verification
The closing of a divided period and a change on the configuration pins can land on the same clock edge. That is the one moment when the new word must be captured and not ignored. The bench drives a new word on the last falling edge before a period ends, and it also drives changes early and in the middle of a period. It then measures two successive pulse intervals. The interval in progress must keep its old length in every case, and the interval that follows must take the new ratio only when the change came before the boundary edge. A second coincidence occurs when a length switch meets the boundary. There, the two upper cells must leave or re-enter the chain cleanly. This is judged by the first long-mode interval after a switch, which must be exact.

// File: rtl/dm23_pkg.sv
package dm23_pkg;
  // Phase of a single 2/3 cell within its own output period.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // first input period of the cell
    PH_TOP   = 2'd1,  // second input period; the stretch decision is taken here
    PH_EXTRA = 2'd2   // stretched third input period
  } ph_t;
endpackage

// File: rtl/dm23_cell.sv
module dm23_cell
  import dm23_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold,     // cell is outside the active chain
  input  logic step,     // one input period of this cell has elapsed
  input  logic swallow,  // program bit AND incoming modulus
  output logic is_top,
  output logic is_extra
);
  ph_t ph;

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      ph <= PH_IDLE;
    end else if (step) begin
      case (ph)
        PH_IDLE: ph <= PH_TOP;
        PH_TOP:  ph <= swallow ? PH_EXTRA : PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign is_top   = (ph == PH_TOP);
  assign is_extra = (ph == PH_EXTRA);
endmodule

// File: rtl/dm23_chain.sv
module dm23_chain #(
  parameter int N  = 10,
  parameter int AW = 4
) (
  input  logic [N-1:0]  is_top,
  input  logic [N-1:0]  is_extra,
  input  logic [N-1:0]  prog,
  input  logic [AW-1:0] act,
  output logic [N-1:0]  step,
  output logic [N-1:0]  swallow,
  output logic [N-1:0]  hold,
  output logic          wrap
);
  logic [N-1:0] fin;  // cell sits in the last input period of its own cycle

  // Modulus ripple: travels from the last active cell towards cell 0.
  always_comb begin
    logic m;
    m = 1'b1;
    for (int i = N - 1; i >= 0; i--) begin
      if (i >= int'(act) - 1) m = 1'b1;
      swallow[i] = prog[i] & m;
      fin[i]     = is_extra[i] | (is_top[i] & ~(prog[i] & m));
      m          = m & fin[i];
    end
  end

  // Enable ripple: travels from cell 0 upwards; wrap marks the period end.
  always_comb begin
    logic e;
    e    = 1'b1;
    wrap = 1'b0;
    for (int i = 0; i < N; i++) begin
      hold[i] = (i >= int'(act));
      step[i] = e & ~hold[i];
      if (i == int'(act) - 1) wrap = e & fin[i];
      e = e & fin[i];
    end
  end
endmodule

// File: rtl/dm23_cfg.sv
module dm23_cfg #(
  parameter int N_SHORT = 8,
  parameter int N_LONG  = 10,
  parameter int AW      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap,
  input  logic              long_in,
  input  logic [N_LONG-1:0] prog_in,
  output logic              long_q,
  output logic [N_LONG-1:0] prog_q,
  output logic [AW-1:0]     act
);
  // Shadow copy: follows the pins during reset and at each period boundary.
  always_ff @(posedge clk) begin
    if (!rst_n || wrap) begin
      long_q <= long_in;
      prog_q <= prog_in;
    end
  end

  assign act = long_q ? AW'(N_LONG) : AW'(N_SHORT);
endmodule

// File: rtl/dm23_divider.sv
module dm23_divider #(
  parameter int N_SHORT = 8,
  parameter int N_LONG  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              long_sel,
  input  logic [N_LONG-1:0] prog,
  output logic              div_out
);
  localparam int AW = $clog2(N_LONG + 1);

  logic              long_q;
  logic [N_LONG-1:0] prog_q;
  logic [AW-1:0]     act;
  logic [N_LONG-1:0] is_top, is_extra, step, swallow, hold, busy;
  logic              wrap_w;

  dm23_cfg #(.N_SHORT(N_SHORT), .N_LONG(N_LONG), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wrap(wrap_w),
    .long_in(long_sel), .prog_in(prog),
    .long_q(long_q), .prog_q(prog_q), .act(act)
  );

  dm23_chain #(.N(N_LONG), .AW(AW)) u_chain (
    .is_top(is_top), .is_extra(is_extra), .prog(prog_q), .act(act),
    .step(step), .swallow(swallow), .hold(hold), .wrap(wrap_w)
  );

  for (genvar g = 0; g < N_LONG; g++) begin : g_cell
    dm23_cell u_cell (
      .clk(clk), .rst_n(rst_n), .hold(hold[g]), .step(step[g]),
      .swallow(swallow[g]), .is_top(is_top[g]), .is_extra(is_extra[g])
    );
  end

  assign busy = is_top | is_extra;

  always_ff @(posedge clk) begin
    if (!rst_n) div_out <= 1'b0;
    else        div_out <= wrap_w;
  end
endmodule

// File: rtl/dm23_checker.sv
module dm23_checker #(
  parameter int N_SHORT = 8,
  parameter int N_LONG  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              div_out,
  input logic              wrap,
  input logic              long_q,
  input logic [N_LONG-1:0] prog_q,
  input logic [N_LONG-1:0] busy
);
  localparam int CW = N_LONG + 2;

  logic [CW-1:0] cnt, expect_len, ratio_now;
  logic          armed;

  always_comb begin
    if (long_q) ratio_now = CW'(1 << N_LONG) + CW'(prog_q);
    else        ratio_now = CW'(1 << N_SHORT) + CW'(prog_q[N_SHORT-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      armed      <= 1'b0;
      expect_len <= '0;
    end else if (div_out) begin
      cnt        <= CW'(1);
      armed      <= 1'b1;
      expect_len <= ratio_now;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // R1
  a_r1_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out);

  // R2 R3: interval between pulses equals the ratio captured at its start
  a_r2_period_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (div_out && armed) |-> (cnt == expect_len));

  // R4
  a_r4_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cnt <= CW'((1 << (N_LONG + 1)) - 1)));

  // R6
  a_r6_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(prog_q) && $stable(long_q)));

  // R5
  if (N_LONG > N_SHORT) begin : g_upper
    a_r5_idle_upper: assert property (@(posedge clk) disable iff (!rst_n)
      !long_q |-> (busy[N_LONG-1:N_SHORT] == '0));
  end
endmodule

bind dm23_divider dm23_checker #(.N_SHORT(N_SHORT), .N_LONG(N_LONG)) u_chk (
  .clk(clk), .rst_n(rst_n), .div_out(div_out), .wrap(wrap_w),
  .long_q(long_q), .prog_q(prog_q), .busy(busy)
);

// File: tb/tb_dm23_divider.sv
module tb_dm23_divider;
  localparam int CLK_PERIOD = 10;
  localparam int N_SHORT    = 8;
  localparam int N_LONG     = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              long_sel = 1'b0;
  logic [N_LONG-1:0] prog = '0;
  logic              div_out;

  int checks = 0;
  int fails  = 0;
  int cur_exp = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dm23_divider #(.N_SHORT(N_SHORT), .N_LONG(N_LONG)) dut (
    .clk(clk), .rst_n(rst_n), .long_sel(long_sel), .prog(prog), .div_out(div_out)
  );

  function automatic int ratio_of(logic l, logic [N_LONG-1:0] p);
    return l ? (1 << N_LONG) + int'(p) : (1 << N_SHORT) + int'(p[N_SHORT-1:0]);
  endfunction

  task automatic check(string tag, int got, int want);
    checks++;
    if (got != want) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, want);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Counts falling edges until a pulse is seen on one of them.
  task automatic to_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (div_out !== 1'b1 && n < 5000);
  endtask

  // Called on the falling edge where a pulse was seen: wait `delay` edges,
  // drive the new setting, and check that the running period keeps cur_exp.
  task automatic step(string tag, int delay, logic l, logic [N_LONG-1:0] p);
    int n = 0;
    int m;
    for (int k = 0; k < delay; k++) begin
      @(negedge clk);
      n++;
    end
    long_sel = l;
    prog     = p;
    to_pulse(m);
    check(tag, n + m, cur_exp);
    cur_exp = ratio_of(l, p);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd20231));
    long_sel = 1'b0;
    prog     = 10'h0A5;
    rst_n    = 1'b0;
    repeat (4) @(negedge clk);
    check("R7", int'(div_out), 0);
    rst_n = 1'b1;
    to_pulse(n);
    check("R7", n, 256 + 165);
    cur_exp = 421;

    @(negedge clk);
    check("R1", int'(div_out), 0);
    to_pulse(n);
    check("R2", n + 1, cur_exp);

    step("R2", 0, 1'b0, 10'h000);   // next 256
    step("R4", 0, 1'b0, 10'h0FF);   // checks 256, next 511
    step("R4", 0, 1'b1, 10'h000);   // checks 511, next 1024
    step("R4", 0, 1'b1, 10'h3FF);   // checks 1024, next 2047
    step("R4", 0, 1'b0, 10'h300);   // checks 2047, next 256 with upper bits set
    step("R5", 0, 1'b0, 10'h0C3);   // checks 256, next 451
    step("R6", 200, 1'b1, 10'h155); // mid-period change: checks 451, next 1365
    step("R6", 1364, 1'b0, 10'h012);// change just before boundary: checks 1365
    step("R6", 0, 1'b1, 10'h2AA);   // boundary change took effect: checks 274

    for (int it = 0; it < 30; it++) begin
      logic              l;
      logic [N_LONG-1:0] p;
      int                d;
      l = 1'($urandom % 2);
      p = N_LONG'($urandom);
      d = (it % 3 == 0) ? 0 : int'($urandom % cur_exp);
      step("R2/R3 random", d, l, p);
    end

    to_pulse(n);
    check("R2/R3 final", n, cur_exp);
    finish_run();
  end
endmodule